// File: doc/BRIEF.md
# Width-Polymorphic Add-Immediate Unit

This unit performs an integer add-immediate in a processor whose register elements can be set to one of four widths instead of a single fixed size. Each operation supplies a source operand, a 12-bit signed immediate, a 2-bit width code for the source element and a separate 2-bit width code for the destination element. The add runs at the source element's width and wraps on overflow. The wrapped sum is then sign-extended, or cut down, to the destination element's width.

The result is placed on a 128-bit bus, and every bit above the destination width is zero. A valid flag comes with it. One operation is accepted per clock whenever the input strobe is high. The result is registered, so it appears one cycle after the strobe and stays unchanged until the next accepted operation.

Top module: `polyaddi_unit`

## Requirements
- R1: The source code and the destination code both pick a width as follows: 2'b00 gives 8 bits, 2'b01 gives DEF_W/2, 2'b10 gives DEF_W and 2'b11 gives 2*DEF_W. With DEF_W=64 these widths are 8, 32, 64 and 128.
- R2: The sum is formed at the source width and wraps modulo 2^(source width). There is no saturation and no trap.
- R3: When the source width is smaller than the 12-bit immediate, only the low source-width bits of the immediate are added. When the source width is larger, the immediate is sign-extended to the source width before the add.
- R4: The wrapped sum is sign-extended to the destination width. When the destination is narrower than the source, the low destination-width bits of the sum are kept. When the two widths are equal, the sum passes through unchanged.
- R5: Every result bit at or above the destination width is zero.
- R6: Source operand bits at or above the source width have no effect on the result.
- R7: The result valid flag is high in exactly the cycle that follows a cycle with the input strobe high.
- R8: A cycle without the input strobe leaves the result bus unchanged.
- R9: A synchronous reset clears the result bus to zero and drops the valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| op_valid_i | input | 1 | Operation strobe |
| src_ew_i | input | 2 | Source element width code |
| dst_ew_i | input | 2 | Destination element width code |
| src_val_i | input | 128 | Source operand (2*DEF_W bits) |
| imm_i | input | 12 | Signed immediate |
| res_valid_o | output | 1 | Result valid |
| res_o | output | 128 | Result, zero above the destination width |

## Verification
Each result is due in the first cycle after the strobe cycle, because exactly one register sits between the inputs and the outputs. The bench drives an operation on a falling edge and removes the strobe on the next falling edge. The capture happens on the rising edge in between, so the bench samples the output at that next falling edge. To check the idle behaviour, the bench runs a cycle with the strobe low and with the inputs scrambled, then confirms at the following falling edge that the valid flag is low and the result has not changed.

// File: rtl/polyaddi_pkg.sv
package polyaddi_pkg;

   typedef enum logic [1:0] {
      EW_BYTE   = 2'b00,
      EW_HALF   = 2'b01,
      EW_FULL   = 2'b10,
      EW_DOUBLE = 2'b11
   } ew_code_t;

   localparam int unsigned EW_COUNT = 4;

   // Width in bits chosen by a width code for a given default width.
   function automatic int unsigned ew_bits(logic [1:0] code, int unsigned def_w);
      case (ew_code_t'(code))
         EW_BYTE:   ew_bits = 8;
         EW_HALF:   ew_bits = def_w / 2;
         EW_FULL:   ew_bits = def_w;
         default:   ew_bits = def_w * 2;
      endcase
   endfunction

endpackage

// File: rtl/polyaddi_lane.sv
module polyaddi_lane #(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned IMM_W  = 12,
   parameter int unsigned OUT_W  = 128
) (
   input  logic [OUT_W-1:0] src_i,
   input  logic [IMM_W-1:0] imm_i,
   output logic [OUT_W-1:0] sum_sx_o
);

   logic [LANE_W-1:0] imm_fit;
   logic [LANE_W-1:0] lane_sum;

   if (LANE_W > OUT_W) begin : g_bad_w
      $error("polyaddi_lane: LANE_W exceeds OUT_W");
   end

   // immediate fitted to lane width: truncated or sign-extended
   if (LANE_W <= IMM_W) begin : g_imm_trunc
      assign imm_fit = imm_i[LANE_W-1:0];
   end else begin : g_imm_sext
      assign imm_fit = {{(LANE_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
   end

   assign lane_sum = src_i[LANE_W-1:0] + imm_fit;

   if (LANE_W == OUT_W) begin : g_full
      assign sum_sx_o = lane_sum;
   end else begin : g_ext
      assign sum_sx_o = {{(OUT_W-LANE_W){lane_sum[LANE_W-1]}}, lane_sum};
   end

endmodule

// File: rtl/polyaddi_core.sv
module polyaddi_core #(
   parameter int unsigned DEF_W = 64,
   parameter int unsigned IMM_W = 12,
   localparam int unsigned OUT_W = 2 * DEF_W
) (
   input  logic [OUT_W-1:0] src_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic [1:0]       src_ew_i,
   output logic [OUT_W-1:0] sum_sx_o
);

   logic [OUT_W-1:0] lane_sum [polyaddi_pkg::EW_COUNT];

   for (genvar g = 0; g < polyaddi_pkg::EW_COUNT; g++) begin : g_lane
      localparam int unsigned LW = polyaddi_pkg::ew_bits(2'(g), DEF_W);
      polyaddi_lane #(
         .LANE_W (LW),
         .IMM_W  (IMM_W),
         .OUT_W  (OUT_W)
      ) u_lane (
         .src_i    (src_i),
         .imm_i    (imm_i),
         .sum_sx_o (lane_sum[g])
      );
   end

   assign sum_sx_o = lane_sum[src_ew_i];

endmodule

// File: rtl/polyaddi_fit.sv
module polyaddi_fit #(
   parameter int unsigned DEF_W = 64,
   localparam int unsigned OUT_W = 2 * DEF_W
) (
   input  logic [OUT_W-1:0] sum_sx_i,
   input  logic [1:0]       dst_ew_i,
   output logic [OUT_W-1:0] fit_o
);

   logic [OUT_W-1:0] dmask [polyaddi_pkg::EW_COUNT];

   for (genvar g = 0; g < polyaddi_pkg::EW_COUNT; g++) begin : g_mask
      localparam int unsigned LW = polyaddi_pkg::ew_bits(2'(g), DEF_W);
      if (LW == OUT_W) begin : g_all
         assign dmask[g] = '1;
      end else begin : g_part
         assign dmask[g] = {{(OUT_W-LW){1'b0}}, {LW{1'b1}}};
      end
   end

   // sum is already sign-extended to OUT_W, so cutting it to the
   // destination width yields the sign extension at that width
   assign fit_o = sum_sx_i & dmask[dst_ew_i];

endmodule

// File: rtl/polyaddi_unit.sv
module polyaddi_unit #(
   parameter int unsigned DEF_W = 64,
   parameter int unsigned IMM_W = 12,
   localparam int unsigned OUT_W = 2 * DEF_W
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             op_valid_i,
   input  logic [1:0]       src_ew_i,
   input  logic [1:0]       dst_ew_i,
   input  logic [OUT_W-1:0] src_val_i,
   input  logic [IMM_W-1:0] imm_i,
   output logic             res_valid_o,
   output logic [OUT_W-1:0] res_o
);

   if ((DEF_W % 2) != 0 || DEF_W / 2 < 16) begin : g_bad_def
      $error("polyaddi_unit: DEF_W must be even with DEF_W/2 >= 16");
   end
   if (IMM_W < 2 || IMM_W > DEF_W / 2) begin : g_bad_imm
      $error("polyaddi_unit: IMM_W out of range");
   end

   logic [OUT_W-1:0] sum_sx;
   logic [OUT_W-1:0] fit;

   polyaddi_core #(
      .DEF_W (DEF_W),
      .IMM_W (IMM_W)
   ) u_core (
      .src_i    (src_val_i),
      .imm_i    (imm_i),
      .src_ew_i (src_ew_i),
      .sum_sx_o (sum_sx)
   );

   polyaddi_fit #(
      .DEF_W (DEF_W)
   ) u_fit (
      .sum_sx_i (sum_sx),
      .dst_ew_i (dst_ew_i),
      .fit_o    (fit)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         res_valid_o <= 1'b0;
         res_o       <= '0;
      end else begin
         res_valid_o <= op_valid_i;
         if (op_valid_i) begin
            res_o <= fit;
         end
      end
   end

   // ---------------- assertions ----------------
   function automatic logic [OUT_W-1:0] low_mask(int unsigned w);
      if (w >= OUT_W) low_mask = '1;
      else            low_mask = (OUT_W'(1) << w) - OUT_W'(1);
   endfunction

   function automatic logic upper_clear(logic [OUT_W-1:0] r, logic [1:0] dcode);
      upper_clear = ((r & ~low_mask(polyaddi_pkg::ew_bits(dcode, DEF_W))) == '0);
   endfunction

   function automatic logic sign_filled(logic [OUT_W-1:0] r, logic [1:0] scode,
                                        logic [1:0] dcode);
      int unsigned sw;
      int unsigned dw;
      logic [OUT_W-1:0] seg;
      sw = polyaddi_pkg::ew_bits(scode, DEF_W);
      dw = polyaddi_pkg::ew_bits(dcode, DEF_W);
      if (dw <= sw) begin
         sign_filled = 1'b1;
      end else begin
         seg = (r & low_mask(dw)) >> (sw - 1);
         sign_filled = (seg == '0) || (seg == low_mask(dw - sw + 1));
      end
   endfunction

   // R7
   valid_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      op_valid_i |=> res_valid_o);

   // R7
   valid_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !op_valid_i |=> !res_valid_o);

   // R8
   hold_result_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !op_valid_i |=> $stable(res_o));

   // R5
   upper_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      op_valid_i |=> upper_clear(res_o, $past(dst_ew_i)));

   // R4
   sign_fill_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      op_valid_i |=> sign_filled(res_o, $past(src_ew_i), $past(dst_ew_i)));

endmodule

// File: tb/polyaddi_unit_bench.sv
module polyaddi_unit_bench;

   localparam int unsigned DEF_W = 64;
   localparam int unsigned IMM_W = 12;
   localparam int unsigned OUT_W = 2 * DEF_W;

   logic             clk = 1'b0;
   logic             rst;
   logic             op_valid;
   logic [1:0]       src_ew;
   logic [1:0]       dst_ew;
   logic [OUT_W-1:0] src_val;
   logic [IMM_W-1:0] imm;
   logic             res_valid;
   logic [OUT_W-1:0] res;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   polyaddi_unit #(.DEF_W(DEF_W), .IMM_W(IMM_W)) u_polyaddi_unit (
      .clk_i       (clk),
      .rst_i       (rst),
      .op_valid_i  (op_valid),
      .src_ew_i    (src_ew),
      .dst_ew_i    (dst_ew),
      .src_val_i   (src_val),
      .imm_i       (imm),
      .res_valid_o (res_valid),
      .res_o       (res)
   );

   // R1 width table, written independently of the design
   function automatic int unsigned wbits(logic [1:0] c);
      case (c)
         2'b00:   return 8;
         2'b01:   return 32;
         2'b10:   return 64;
         default: return 128;
      endcase
   endfunction

   function automatic logic [OUT_W-1:0] msk(int unsigned w);
      logic [OUT_W-1:0] m = '0;
      for (int i = 0; i < OUT_W; i++) if (i < w) m[i] = 1'b1;
      return m;
   endfunction

   function automatic logic [OUT_W-1:0] model(logic [1:0] s, logic [1:0] d,
                                              logic [OUT_W-1:0] a, logic [IMM_W-1:0] k);
      int unsigned sw = wbits(s);
      int unsigned dw = wbits(d);
      logic [OUT_W-1:0] kx = {{(OUT_W-IMM_W){k[IMM_W-1]}}, k};
      logic [OUT_W-1:0] sum = ((a & msk(sw)) + kx) & msk(sw);
      if (sum[sw-1]) sum = sum | ~msk(sw);
      return sum & msk(dw);
   endfunction

   task automatic check(logic ok, string req, logic [OUT_W-1:0] act,
                        logic [OUT_W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive one operation and check the result one cycle later
   task automatic run_op(logic [1:0] s, logic [1:0] d, logic [OUT_W-1:0] a,
                         logic [IMM_W-1:0] k, string req);
      logic [OUT_W-1:0] e;
      e = model(s, d, a, k);
      @(negedge clk);
      src_ew = s; dst_ew = d; src_val = a; imm = k; op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      check(res_valid == 1'b1, {req, " valid (R7)"}, OUT_W'(res_valid), OUT_W'(1));
      check(res == e, req, res, e);
   endtask

   initial begin
      logic [OUT_W-1:0] held;
      logic [OUT_W-1:0] big;
      void'($urandom(32'd20181021));
      rst = 1'b1; op_valid = 1'b0; src_ew = '0; dst_ew = '0;
      src_val = '0; imm = '0;
      repeat (3) @(negedge clk);
      // R9 reset state
      check(res_valid == 1'b0, "R9 valid", OUT_W'(res_valid), '0);
      check(res == '0, "R9 result", res, '0);
      rst = 1'b0;

      // R3 truncated immediate at 8 bits: 0x7F + 0x3FF wraps
      run_op(2'b00, 2'b10, OUT_W'(8'h7F), 12'h3FF, "R3 8-bit trunc");
      check(res == OUT_W'(64'h7E), "R2 wrap 0x7E", res, OUT_W'(64'h7E));

      // every src/dst combination: most negative immediate and the 0x7F case
      for (int s = 0; s < 4; s++) begin
         for (int d = 0; d < 4; d++) begin
            run_op(2'(s), 2'(d), '0, 12'h800, "R4 min imm combo");
            run_op(2'(s), 2'(d), OUT_W'(8'h7F), 12'h3FF, "R1 combo 7F+3FF");
            run_op(2'(s), 2'(d), msk(wbits(2'(s))) >> 1, 12'h001, "R2 signed overflow");
         end
      end

      // R4 equal widths: sum unchanged; R5 upper bits zero
      run_op(2'b01, 2'b01, OUT_W'(32'h1234_5678), 12'h7FF, "R4 equal widths");
      run_op(2'b11, 2'b00, {OUT_W{1'b1}}, 12'h002, "R4 narrow dst");
      check((res & ~msk(8)) == '0, "R5 upper zero", res, res & msk(8));

      // R6 junk above source width is ignored
      big = {{(OUT_W-8){1'b1}}, 8'h10};
      run_op(2'b00, 2'b11, big, 12'h005, "R6 ignore upper src");
      check(res == OUT_W'(8'h15), "R6 value", res, OUT_W'(8'h15));
      big = {{(OUT_W-32){1'b1}}, 32'h0000_0001};
      run_op(2'b01, 2'b10, big, 12'hFFF, "R6 ignore upper src 32");
      check(res == '0, "R6 value 32", res, '0);

      // R8 hold and R7 idle: strobe low, inputs scrambled
      held = res;
      @(negedge clk);
      src_val = {4{$urandom}}; imm = 12'($urandom); src_ew = 2'b11; dst_ew = 2'b11;
      @(negedge clk);
      check(res_valid == 1'b0, "R7 idle valid", OUT_W'(res_valid), '0);
      check(res == held, "R8 hold", res, held);

      // constrained random
      for (int n = 0; n < 400; n++) begin
         run_op(2'($urandom), 2'($urandom), {$urandom, $urandom, $urandom, $urandom},
                12'($urandom), "R2 random");
      end

      // R9 reset after activity
      @(negedge clk); rst = 1'b1;
      @(negedge clk);
      check(res == '0 && res_valid == 1'b0, "R9 re-reset", res, '0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule